// File: doc/BRIEF.md
# Indirect Configuration and Port Access Bridge

This block gives a host a narrow register window through which it reaches three downstream address spaces: configuration space, I/O port space and memory space. The host first loads a shared 32-bit target register. It then reads or writes one of three data windows. Each window access becomes exactly one downstream cycle of the window's type. That cycle carries the stored target, byte enables derived from the window offset and the access size, and write data moved onto the matching byte lanes. The host access stalls until the downstream side answers. Read data is then shifted back down to bit 0 and returned.

The downstream side is a plain request/acknowledge handshake that stands in for the real bus protocol. A dedicated setup cycle guarantees that cycle type, address, byte enables and write data are all settled one full cycle before the request rises. Without it, a cycle could start on stale values left over from a cycle of a different type. A downstream abort returns all ones to a reading host and sets a sticky error flag.

The sequencer has four states. S_IDLE waits for a host request. From S_IDLE, a window access latches its fields and moves to S_SETUP; any other access moves straight to S_RESP. S_SETUP always moves to S_ISSUE. S_ISSUE holds the downstream request and moves to S_RESP when the acknowledge arrives. S_RESP presents one ready pulse and always returns to S_IDLE.

Top module: `cfgio_bridge`

## Requirements
- R1: After reset, host_ready, ds_req and err_flag are 0, and a read of the target register (offset 0x064) returns 0.
- R2: A host write to offset 0x064 of any size loads all 32 bits of host_wdata into the target register, and a read of 0x064 returns it. The value persists across any number of data-window accesses.
- R3: An access to offsets 0x068..0x06B issues one downstream cycle with ds_kind=2'b00 (configuration), ds_we equal to host_we, and ds_addr equal to the target register with bits 1:0 forced to 0.
- R4: An access to offsets 0x06C..0x06F issues one downstream cycle with ds_kind=2'b01 (I/O port) and ds_addr equal to target bits 15:0, zero-extended.
- R5: An access to offsets 0x070..0x073 issues one downstream cycle with ds_kind=2'b10 (memory) and ds_addr equal to the target register with bits 1:0 forced to 0.
- R6: host_size encodes 2'b00 byte, 2'b01 halfword, and 2'b10 or 2'b11 word. ds_be is 0001, 0010, 0100 or 1000 for a byte at offset bits 1:0 = 0, 1, 2, 3. It is 0011 or 1100 for a halfword with offset bit 1 = 0 or 1. It is 1111 for a word.
- R7: Write data is right-justified on host_wdata. The low 8, 16 or 32 bits (by size) are placed on ds_wdata shifted up by 8 times the lane index (byte: offset bits 1:0; halfword: 2 times offset bit 1; word: 0), with all other bits 0.
- R8: A successful window read returns ds_rdata shifted down by 8 times the lane index and masked to the access size, with the upper bits 0.
- R9: ds_req rises only after ds_kind, ds_addr, ds_be, ds_we and ds_wdata have held their values for one full cycle. It stays high with those values stable until the cycle in which ds_ack is seen. A configuration read with target 0 completes like any other.
- R10: host_ready is a single-cycle pulse. A window access gives ready 3+L cycles after the request is first sampled, where L is the number of cycles ds_ack lags behind ds_req. A register or unmapped access gives ready after 1 cycle and issues no downstream cycle.
- R11: When ds_ack arrives with ds_abort=1, a read returns 0xFFFFFFFF. For a read or a write, err_flag becomes 1 and stays 1 until reset.
- R12: A write to an offset outside 0x064..0x073 changes nothing, and a read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | OFF_W (12) | Byte offset of the access |
| host_size | input | 2 | Access size code (see R6) |
| host_wdata | input | DATA_W (32) | Right-justified write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W (32) | Right-justified read data, valid with host_ready |
| ds_req | output | 1 | Downstream cycle request |
| ds_we | output | 1 | Downstream write |
| ds_kind | output | 2 | Cycle type: 00 config, 01 I/O, 10 memory |
| ds_addr | output | DATA_W (32) | Downstream address |
| ds_be | output | DATA_W/8 (4) | Active-high byte enables |
| ds_wdata | output | DATA_W (32) | Lane-positioned write data |
| ds_ack | input | 1 | Downstream completion |
| ds_abort | input | 1 | Completion ended in master abort (valid with ds_ack) |
| ds_rdata | input | DATA_W (32) | Lane-positioned read data (valid with ds_ack) |
| err_flag | output | 1 | Sticky abort flag |

## Verification
The bench builds the bridge with its defaults: a 12-bit host offset and a 32-bit data path, so four byte lanes. This puts every byte position, both halfword positions and the word case within reach of each window. The responder acknowledges with zero wait cycles and with three wait cycles, which exercises the hold of a pending request and the stall of the host. It also switches between configuration, I/O and memory cycles back to back, so the settle-before-request rule is tested across a change of type.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;

    // Host-visible offsets of the register window
    localparam int unsigned OFF_TARGET = 'h064;
    localparam int unsigned OFF_WCFG   = 'h068;
    localparam int unsigned OFF_WIO    = 'h06C;
    localparam int unsigned OFF_WMEM   = 'h070;

    typedef enum logic [1:0] {
        KIND_CFG = 2'b00,
        KIND_IO  = 2'b01,
        KIND_MEM = 2'b10
    } kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETUP,
        S_ISSUE,
        S_RESP
    } seq_state_e;

endpackage

// File: rtl/cfgio_decode.sv
module cfgio_decode
    import cfgio_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int LANES  = 4,
    parameter int LIDX_W = 2
) (
    input  logic [OFF_W-1:0]  off,
    input  size_e             size,
    output logic              hit_win,
    output logic              hit_target,
    output kind_e             kind,
    output logic [LIDX_W-1:0] lane,
    output logic [LANES-1:0]  be
);

    logic [OFF_W-1:0] base;
    assign base = {off[OFF_W-1:LIDX_W], {LIDX_W{1'b0}}};

    // Which register or window the access lands in
    always_comb begin
        hit_target = (base == OFF_W'(OFF_TARGET));
        hit_win    = 1'b1;
        kind       = KIND_CFG;
        if (base == OFF_W'(OFF_WCFG)) begin
            kind = KIND_CFG;
        end else if (base == OFF_W'(OFF_WIO)) begin
            kind = KIND_IO;
        end else if (base == OFF_W'(OFF_WMEM)) begin
            kind = KIND_MEM;
        end else begin
            hit_win = 1'b0;
        end
    end

    // Lane index and byte enables from size and low offset bits
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                lane = off[LIDX_W-1:0];
                be   = LANES'(1) << lane;
            end
            SZ_HALF: begin
                lane = {off[LIDX_W-1:1], 1'b0};
                be   = LANES'(3) << lane;
            end
            default: begin
                lane = '0;
                be   = '1;
            end
        endcase
    end

endmodule

// File: rtl/cfgio_lanes.sv
module cfgio_lanes
    import cfgio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = 2
) (
    input  logic [LIDX_W-1:0] lane,
    input  size_e             size,
    input  logic [DATA_W-1:0] wdata_just,
    input  logic [DATA_W-1:0] rdata_lanes,
    output logic [DATA_W-1:0] wdata_lanes,
    output logic [DATA_W-1:0] rdata_just
);

    localparam int SH_W = LIDX_W + 3;

    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] rd_down;
    logic [DATA_W-1:0] wr_masked;
    logic [LANES-1:0]  keep;

    assign shamt   = {lane, 3'b000};
    assign rd_down = rdata_lanes >> shamt;

    // Per-lane keep mask: one lane for a byte, two for a halfword
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign keep[i] = (size == SZ_BYTE) ? (i == 0) :
                         (size == SZ_HALF) ? (i < 2)  : 1'b1;
        assign rdata_just[8*i +: 8] = keep[i] ? rd_down[8*i +: 8]    : 8'h00;
        assign wr_masked[8*i +: 8]  = keep[i] ? wdata_just[8*i +: 8] : 8'h00;
    end

    assign wdata_lanes = wr_masked << shamt;

endmodule

// File: rtl/cfgio_seq.sv
module cfgio_seq
    import cfgio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              dec_win,
    input  logic              dec_target,
    input  kind_e             dec_kind,
    input  logic [LIDX_W-1:0] dec_lane,
    input  size_e             dec_size,
    input  logic [LANES-1:0]  dec_be,
    input  logic [DATA_W-1:0] target_q,
    input  logic [DATA_W-1:0] rd_just,
    input  logic              ds_ack,
    input  logic              ds_abort,
    output logic              target_we,
    output logic              ds_req,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output kind_e             kind_q,
    output logic              we_q,
    output logic [LANES-1:0]  be_q,
    output logic [LIDX_W-1:0] lane_q,
    output size_e             size_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              err_flag
);

    seq_state_e st, nx;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    // Next state
    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE:  if (host_req) nx = dec_win ? S_SETUP : S_RESP;
            S_SETUP: nx = S_ISSUE;
            S_ISSUE: if (ds_ack) nx = S_RESP;
            S_RESP:  nx = S_IDLE;
            default: nx = S_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        ds_req     = (st == S_ISSUE);
        host_ready = (st == S_RESP);
        target_we  = (st == S_IDLE) && host_req && host_we && dec_target;
    end

    // Request fields, result and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= KIND_CFG;
            we_q    <= 1'b0;
            be_q    <= '0;
            lane_q  <= '0;
            size_q  <= SZ_WORD;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (host_req) begin
                        if (dec_win) begin
                            kind_q  <= dec_kind;
                            we_q    <= host_we;
                            be_q    <= dec_be;
                            lane_q  <= dec_lane;
                            size_q  <= dec_size;
                            wdata_q <= host_wdata;
                        end else begin
                            rdata_q <= (dec_target && !host_we) ? target_q : '0;
                        end
                    end
                end
                S_ISSUE: begin
                    if (ds_ack) begin
                        if (ds_abort) err_q <= 1'b1;
                        if (we_q)          rdata_q <= '0;
                        else if (ds_abort) rdata_q <= '1;
                        else               rdata_q <= rd_just;
                    end
                end
                default: ;
            endcase
        end
    end

    assign host_rdata = rdata_q;
    assign err_flag   = err_q;

endmodule

// File: rtl/cfgio_bridge.sv
module cfgio_bridge
    import cfgio_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [OFF_W-1:0]      host_addr,
    input  logic [1:0]            host_size,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic                  host_ready,
    output logic [DATA_W-1:0]     host_rdata,
    output logic                  ds_req,
    output logic                  ds_we,
    output logic [1:0]            ds_kind,
    output logic [DATA_W-1:0]     ds_addr,
    output logic [DATA_W/8-1:0]   ds_be,
    output logic [DATA_W-1:0]     ds_wdata,
    input  logic                  ds_ack,
    input  logic                  ds_abort,
    input  logic [DATA_W-1:0]     ds_rdata,
    output logic                  err_flag
);

    localparam int LANES  = DATA_W / 8;
    localparam int LIDX_W = $clog2(LANES);
    localparam int PORT_W = 16;

    logic              dec_win, dec_target;
    kind_e             dec_kind;
    logic [LIDX_W-1:0] dec_lane;
    logic [LANES-1:0]  dec_be;
    size_e             dec_size;

    logic              target_we;
    logic [DATA_W-1:0] target_q;
    kind_e             kind_q;
    logic [LIDX_W-1:0] lane_q;
    size_e             size_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_just;

    assign dec_size = size_e'(host_size);

    cfgio_decode #(.OFF_W(OFF_W), .LANES(LANES), .LIDX_W(LIDX_W)) u_dec (
        .off        (host_addr),
        .size       (dec_size),
        .hit_win    (dec_win),
        .hit_target (dec_target),
        .kind       (dec_kind),
        .lane       (dec_lane),
        .be         (dec_be)
    );

    // Shared target register, kept across data accesses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         target_q <= '0;
        else if (target_we) target_q <= host_wdata;
    end

    cfgio_seq #(.DATA_W(DATA_W), .LANES(LANES), .LIDX_W(LIDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .dec_win    (dec_win),
        .dec_target (dec_target),
        .dec_kind   (dec_kind),
        .dec_lane   (dec_lane),
        .dec_size   (dec_size),
        .dec_be     (dec_be),
        .target_q   (target_q),
        .rd_just    (rd_just),
        .ds_ack     (ds_ack),
        .ds_abort   (ds_abort),
        .target_we  (target_we),
        .ds_req     (ds_req),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .kind_q     (kind_q),
        .we_q       (ds_we),
        .be_q       (ds_be),
        .lane_q     (lane_q),
        .size_q     (size_q),
        .wdata_q    (wdata_q),
        .err_flag   (err_flag)
    );

    cfgio_lanes #(.DATA_W(DATA_W), .LANES(LANES), .LIDX_W(LIDX_W)) u_lanes (
        .lane        (lane_q),
        .size        (size_q),
        .wdata_just  (wdata_q),
        .rdata_lanes (ds_rdata),
        .wdata_lanes (ds_wdata),
        .rdata_just  (rd_just)
    );

    // Address formed per cycle type from the target register
    always_comb begin
        if (kind_q == KIND_IO)
            ds_addr = {{(DATA_W-PORT_W){1'b0}}, target_q[PORT_W-1:0]};
        else
            ds_addr = {target_q[DATA_W-1:LIDX_W], {LIDX_W{1'b0}}};
    end

    assign ds_kind = kind_q;

endmodule

// File: rtl/cfgio_bridge_chk.sv
module cfgio_bridge_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ds_req,
    input logic                ds_ack,
    input logic                ds_abort,
    input logic                ds_we,
    input logic [1:0]          ds_kind,
    input logic [DATA_W-1:0]   ds_addr,
    input logic [DATA_W/8-1:0] ds_be,
    input logic [DATA_W-1:0]   ds_wdata,
    input logic                host_ready,
    input logic [DATA_W-1:0]   host_rdata,
    input logic                err_flag
);

    p_settle_before_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_req) |-> $stable(ds_kind) && $stable(ds_addr) && $stable(ds_be)
                          && $stable(ds_we) && $stable(ds_wdata));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req && !ds_ack) |=> ds_req && $stable(ds_kind) && $stable(ds_addr)
                                && $stable(ds_be));

    p_be_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req |-> ($countones(ds_be) == 1) || (ds_be == 4'b0011)
                   || (ds_be == 4'b1100) || (ds_be == 4'b1111));

    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    p_ready_not_during_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !ds_req);

    p_ack_to_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req && ds_ack) |=> host_ready && !ds_req);

    p_abort_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req && ds_ack && ds_abort && !ds_we) |=> host_rdata == '1);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_err_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req && ds_ack && ds_abort) |=> err_flag);

endmodule

bind cfgio_bridge cfgio_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ds_req     (ds_req),
    .ds_ack     (ds_ack),
    .ds_abort   (ds_abort),
    .ds_we      (ds_we),
    .ds_kind    (ds_kind),
    .ds_addr    (ds_addr),
    .ds_be      (ds_be),
    .ds_wdata   (ds_wdata),
    .host_ready (host_ready),
    .host_rdata (host_rdata),
    .err_flag   (err_flag)
);

// File: tb/tb_cfgio_bridge.sv
`timescale 1ns/1ps
module tb_cfgio_bridge;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        ds_req, ds_we;
    logic [1:0]  ds_kind;
    logic [31:0] ds_addr, ds_wdata;
    logic [3:0]  ds_be;
    logic        ds_ack = 1'b0;
    logic        ds_abort = 1'b0;
    logic [31:0] ds_rdata = '0;
    logic        err_flag;

    int checks = 0;
    int bad = 0;
    int lat = 0;
    int wcnt = 0;
    logic abort_next = 1'b0;
    logic finished = 1'b0;

    // expected downstream item: {kind, we, addr, be, wdata}
    logic [70:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgio_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .ds_req(ds_req), .ds_we(ds_we), .ds_kind(ds_kind), .ds_addr(ds_addr),
        .ds_be(ds_be), .ds_wdata(ds_wdata), .ds_ack(ds_ack),
        .ds_abort(ds_abort), .ds_rdata(ds_rdata), .err_flag(err_flag)
    );

    function automatic logic [31:0] resp_of(input logic [31:0] a);
        return a ^ 32'h5A3C_9617;
    endfunction

    function automatic int lane_of(input logic [11:0] off, input logic [1:0] sz);
        if (sz == 2'b00) return int'(off[1:0]);
        if (sz == 2'b01) return off[1] ? 2 : 0;
        return 0;
    endfunction

    function automatic logic [31:0] mask_of(input logic [1:0] sz);
        if (sz == 2'b00) return 32'h0000_00FF;
        if (sz == 2'b01) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [3:0] be_of(input logic [11:0] off, input logic [1:0] sz);
        if (sz == 2'b00) return 4'b0001 << off[1:0];
        if (sz == 2'b01) return off[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Responder: ack after lat wait cycles, read data from address
    always @(negedge clk) begin
        if (ds_ack) begin
            ds_ack = 1'b0;
            ds_abort = 1'b0;
            wcnt = 0;
        end else if (ds_req) begin
            if (wcnt == lat) begin
                ds_ack = 1'b1;
                ds_rdata = resp_of(ds_addr);
                ds_abort = abort_next;
                abort_next = 1'b0;
            end else begin
                wcnt++;
            end
        end
    end

    // Monitor: settle check and scoreboard compare at each request start
    logic        in_cyc = 1'b0;
    logic [1:0]  pk = '0;
    logic [31:0] pa = '0;
    logic [3:0]  pb = '0;
    always @(negedge clk) begin
        if (ds_req && !in_cyc) begin
            in_cyc = 1'b1;
            check(pk == ds_kind && pa == ds_addr && pb == ds_be,
                  "R9 fields settled before request", {28'd0, ds_be}, {28'd0, pb});
            if (exp_q.size() == 0) begin
                check(1'b0, "R10/R12 unexpected downstream cycle", ds_addr, 32'h0);
            end else begin
                logic [70:0] e;
                e = exp_q.pop_front();
                check(ds_kind == e[70:69], "R3/R4/R5 cycle kind",
                      {30'd0, ds_kind}, {30'd0, e[70:69]});
                check(ds_we == e[68], "R3 cycle direction", {31'd0, ds_we}, {31'd0, e[68]});
                check(ds_addr == e[67:36], "R3/R4/R5 cycle address", ds_addr, e[67:36]);
                check(ds_be == e[35:32], "R6 byte enables", {28'd0, ds_be}, {28'd0, e[35:32]});
                if (e[68])
                    check(ds_wdata == e[31:0], "R7 write lanes", ds_wdata, e[31:0]);
            end
        end else if (!ds_req) begin
            in_cyc = 1'b0;
        end
        pk = ds_kind;
        pa = ds_addr;
        pb = ds_be;
    end

    task automatic xfer(input logic we, input logic [11:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = off; host_size = sz; host_wdata = wd;
        cyc = 0;
        do begin
            @(posedge clk); #1;
            cyc++;
        end while (!host_ready && cyc < 500);
        rd = host_rdata;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    // Window access with expectations pushed to the scoreboard
    task automatic win(input logic we, input logic [11:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] target,
                       input bit abort, input string tag);
        logic [1:0]  k;
        logic [31:0] a, rd, exp_rd;
        int cyc, ln;
        ln = lane_of(off, sz);
        k = (off[11:2] == 10'h01A) ? 2'b00 : (off[11:2] == 10'h01B) ? 2'b01 : 2'b10;
        a = (k == 2'b01) ? {16'd0, target[15:0]} : {target[31:2], 2'b00};
        exp_q.push_back({k, we, a, be_of(off, sz), (wd & mask_of(sz)) << (8*ln)});
        abort_next = abort;
        xfer(we, off, sz, wd, rd, cyc);
        check(cyc == 3 + lat, {tag, " R10 latency"}, cyc, 3 + lat);
        if (!we) begin
            exp_rd = abort ? 32'hFFFF_FFFF : (resp_of(a) >> (8*ln)) & mask_of(sz);
            check(rd == exp_rd, {tag, abort ? " R11 abort read" : " R8 read lanes"}, rd, exp_rd);
        end
    endtask

    task automatic reg_wr(input logic [11:0] off, input logic [31:0] v, input string tag);
        logic [31:0] rd;
        int cyc;
        xfer(1'b1, off, 2'b10, v, rd, cyc);
        check(cyc == 1, {tag, " R10 register latency"}, cyc, 1);
    endtask

    task automatic reg_rd(input logic [11:0] off, input logic [31:0] exp, input string tag);
        logic [31:0] rd;
        int cyc;
        xfer(1'b0, off, 2'b10, 32'h0, rd, cyc);
        check(rd == exp, tag, rd, exp);
        check(cyc == 1, {tag, " R10 register latency"}, cyc, 1);
    endtask

    initial begin
        logic [31:0] t;
        repeat (3) @(posedge clk);
        #1;
        check(!host_ready && !ds_req && !err_flag, "R1 reset outputs",
              {29'd0, host_ready, ds_req, err_flag}, 32'h0);
        rst_n = 1'b1;
        reg_rd(12'h064, 32'h0, "R1 target after reset");

        // configuration: bus 3, dev/fn 0x2A, register 0x3C
        t = 32'h0003_2A3C;
        reg_wr(12'h064, t, "R2 load");
        reg_rd(12'h064, t, "R2 read back");
        win(1'b0, 12'h068, 2'b10, 32'h0, t, 1'b0, "R3 cfg word read");
        win(1'b0, 12'h06B, 2'b00, 32'h0, t, 1'b0, "R6 cfg byte3 read");
        win(1'b1, 12'h06A, 2'b01, 32'h1234_BEEF, t, 1'b0, "R7 cfg upper half write");
        win(1'b1, 12'h069, 2'b00, 32'h0000_1234, t, 1'b0, "R7 cfg byte1 write");
        win(1'b0, 12'h068, 2'b01, 32'h0, t, 1'b0, "R8 cfg lower half read");
        reg_rd(12'h064, t, "R2 target persists");

        // I/O port with slow responder
        lat = 3;
        t = 32'h1234_8766;
        reg_wr(12'h064, t, "R2 load io");
        win(1'b0, 12'h06E, 2'b00, 32'h0, t, 1'b0, "R4 io byte2 read");
        win(1'b1, 12'h06C, 2'b10, 32'hCAFE_F00D, t, 1'b0, "R4 io word write");
        win(1'b0, 12'h06F, 2'b11, 32'h0, t, 1'b0, "R6 size 11 as word");

        // memory, then type switches back to back
        lat = 0;
        t = 32'h8000_1237;
        reg_wr(12'h064, t, "R2 load mem");
        win(1'b0, 12'h070, 2'b01, 32'h0, t, 1'b0, "R5 mem half read");
        win(1'b1, 12'h073, 2'b00, 32'h0000_00A5, t, 1'b0, "R5 mem byte3 write");
        win(1'b0, 12'h06C, 2'b01, 32'h0, t, 1'b0, "R9 io after mem");
        t = 32'h0;
        reg_wr(12'h064, t, "R2 load zero");
        win(1'b0, 12'h068, 2'b10, 32'h0, t, 1'b0, "R9 separating cfg read reg0");
        win(1'b1, 12'h070, 2'b10, 32'h7777_1111, t, 1'b0, "R9 mem after cfg");

        // abort handling
        t = 32'h0001_0800;
        reg_wr(12'h064, t, "R2 load abort");
        check(!err_flag, "R11 flag clear before abort", {31'd0, err_flag}, 32'h0);
        win(1'b0, 12'h069, 2'b00, 32'h0, t, 1'b1, "R11 abort");
        #1;
        check(err_flag, "R11 flag set", {31'd0, err_flag}, 32'h1);
        win(1'b0, 12'h068, 2'b10, 32'h0, t, 1'b0, "R11 normal after abort");
        check(err_flag, "R11 flag sticky", {31'd0, err_flag}, 32'h1);

        // unmapped offsets
        reg_wr(12'h074, 32'hDEAD_BEEF, "R12 write unmapped");
        reg_wr(12'h060, 32'h0BAD_0BAD, "R12 write below target");
        reg_rd(12'h064, t, "R12 target untouched");
        reg_rd(12'h074, 32'h0, "R12 read unmapped");
        reg_rd(12'h000, 32'h0, "R12 read offset 0");

        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "R10 all expected cycles issued", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule